// File: doc/BRIEF.md
# Programmable Input/Output Register Pins

This block owns a bank of general-purpose pins (eight by default). Each pin can be set up as an input or as an output. A processor reaches the whole bank through one 16-bit bus location. A direction register holds the setup. It drives the output-enable vector of the pads directly. A drive register holds the level placed on the pins that are set up as outputs. The pins that are set up as inputs pass through a per-pin synchronizer. The last stage of that synchronizer is the input sample register that software reads.

One location serves all three registers. On a write, the bit just above the pin field chooses the target. When it is set, the low byte goes to the direction register. When it is clear, the low byte goes to the drive register, but only the bits configured as outputs take the new value. A read returns one status byte with the direction byte above it. In the status byte, each input bit shows its sampled pin level and each output bit shows its drive value. An access counts only when the active-low select is low and the address is zero.

Top module: `sfp_port`

## Requirements
- R1: While reset is asserted, and right after it, the direction register and the drive register are all zero. So `pin_oe` and `pin_out` read 0, and a read returns 0 in its upper byte.
- R2: A selected write whose bit 8 is 1 loads `acc_wdata[7:0]` into the direction register. A bit value of 1 makes the pin an output and 0 makes it an input. The new value shows on `pin_oe` after the next rising edge.
- R3: A selected write whose bit 8 is 0 loads `acc_wdata[n]` into drive bit n only where direction bit n is 1. A drive bit whose direction is input keeps its earlier value.
- R4: `pin_oe` always equals the direction register and `pin_out` always equals the drive register, where 1 is on and 0 is off.
- R5: On a selected read, `acc_rdata[n]` for n in 0..7 is the registered pin sample when direction bit n is 0, and drive bit n when direction bit n is 1.
- R6: On a selected read, `acc_rdata[15:8]` equals direction bits 7..0.
- R7: A level change on `pin_in` shows in reads after exactly two rising edges and not after one. No path from the pin to the read data is combinational.
- R8: An access with `acc_en_n` high or with a nonzero address changes no register. In that case, and on any cycle that is not a selected read, `acc_rdata` is 0.
- R9: A direction write leaves the drive register unchanged. A pin switched back to output therefore drives its earlier value again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized inside |
| acc_en_n | input | 1 | Active-low select for the register location |
| acc_addr | input | ADDR_W (2) | Bus address; only 0 selects the bank |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_wdata | input | 16 | Write data; bit 8 steers the target, bits 7..0 carry the value |
| acc_rdata | output | 16 | Read data: direction in 15..8, status in 7..0 |
| pin_in | input | 8 | Pin levels from the pads |
| pin_oe | output | 8 | Per-pin output enable |
| pin_out | output | 8 | Per-pin driven level |

## Verification
The direction register is set to different shapes: upper nibble output, lower nibble output, all output and all input. Each shape is combined with pin patterns that disagree with the drive value. A read then shows whether every status bit picked the pin sample or the drive value. Drive writes are given data with 1s in positions configured as input, which exposes any bit that ignores its direction mask. Accesses with a nonzero address or with the select high are mixed in to show that decode stops them. A directed pin toggle is sampled after zero, one and two edges to fix the synchronizer latency exactly.

// File: rtl/sfp_pkg.sv
package sfp_pkg;
  // Decoded bus operation for one cycle.
  typedef enum logic [1:0] {
    ACC_NONE   = 2'd0,
    ACC_DIR_WR = 2'd1,
    ACC_DRV_WR = 2'd2,
    ACC_READ   = 2'd3
  } acc_e;

  // Merge new bits into a register under a per-bit mask.
  function automatic logic [63:0] mask_merge(input logic [63:0] old_v,
                                             input logic [63:0] new_v,
                                             input logic [63:0] mask);
    return (old_v & ~mask) | (new_v & mask);
  endfunction
endpackage

// File: rtl/sfp_rst_sync.sv
// Asynchronous assertion, synchronous release of the active-low reset.
module sfp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] shf_q;
  logic [STAGES-1:0] shf_d;

  always_comb begin
    shf_d = {shf_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shf_q <= '0;
    else        shf_q <= shf_d;
  end

  assign rst_sync_n = shf_q[STAGES-1];
endmodule

// File: rtl/sfp_sync_bank.sv
// Per-pin synchronizer chain; the final stage is the input sample register.
module sfp_sync_bank #(
  parameter int NPIN   = 8,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_in,
  output logic [NPIN-1:0] sample_q
);
  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb begin
      chain_d = {chain_q[STAGES-2:0], pin_in[i]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= chain_d;
    end

    assign sample_q[i] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/sfp_ctrl_regs.sv
// Direction and drive registers with steered, masked updates.
module sfp_ctrl_regs
  import sfp_pkg::*;
#(
  parameter int NPIN = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  acc_e            acc_op,
  input  logic [NPIN-1:0] wbits,
  output logic [NPIN-1:0] dir_q,
  output logic [NPIN-1:0] drv_q
);
  logic [NPIN-1:0] dir_d;
  logic [NPIN-1:0] drv_d;
  logic            dir_ce;
  logic            drv_ce;
  logic [63:0]     merged;

  always_comb begin
    dir_ce = (acc_op == ACC_DIR_WR);
    drv_ce = (acc_op == ACC_DRV_WR);
    merged = mask_merge(64'(drv_q), 64'(wbits), 64'(dir_q));
    dir_d  = dir_ce ? wbits : dir_q;
    drv_d  = drv_ce ? merged[NPIN-1:0] : drv_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      drv_q <= '0;
    end else begin
      if (dir_ce) dir_q <= dir_d;
      if (drv_ce) drv_q <= drv_d;
    end
  end

  logic [63:0] unused_merged_hi;
  assign unused_merged_hi = merged;
endmodule

// File: rtl/sfp_read_mux.sv
// Read data assembly: per-bit status selection plus direction byte.
module sfp_read_mux #(
  parameter int NPIN = 8
) (
  input  logic              rd_en,
  input  logic [NPIN-1:0]   dir_q,
  input  logic [NPIN-1:0]   drv_q,
  input  logic [NPIN-1:0]   sample_q,
  output logic [2*NPIN-1:0] rdata
);
  for (genvar i = 0; i < NPIN; i++) begin : g_bit
    always_comb begin
      rdata[i]        = rd_en & (dir_q[i] ? drv_q[i] : sample_q[i]);
      rdata[NPIN + i] = rd_en & dir_q[i];
    end
  end
endmodule

// File: rtl/sfp_port.sv
module sfp_port
  import sfp_pkg::*;
#(
  parameter int NPIN        = 8,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en_n,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  input  logic [2*NPIN-1:0] acc_wdata,
  output logic [2*NPIN-1:0] acc_rdata,
  input  logic [NPIN-1:0]   pin_in,
  output logic [NPIN-1:0]   pin_oe,
  output logic [NPIN-1:0]   pin_out
);
  localparam int DATA_W  = 2 * NPIN;
  localparam int STEER_B = NPIN;

  logic            rst_sync_n;
  logic            sel;
  acc_e            acc_op;
  logic [NPIN-1:0] dir_q;
  logic [NPIN-1:0] drv_q;
  logic [NPIN-1:0] sample_q;

  sfp_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    sel = !acc_en_n && (acc_addr == '0);
    if (!sel)                      acc_op = ACC_NONE;
    else if (!acc_write)           acc_op = ACC_READ;
    else if (acc_wdata[STEER_B])   acc_op = ACC_DIR_WR;
    else                           acc_op = ACC_DRV_WR;
  end

  sfp_sync_bank #(.NPIN(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .pin_in   (pin_in),
    .sample_q (sample_q)
  );

  sfp_ctrl_regs #(.NPIN(NPIN)) u_regs (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .acc_op (acc_op),
    .wbits  (acc_wdata[NPIN-1:0]),
    .dir_q  (dir_q),
    .drv_q  (drv_q)
  );

  sfp_read_mux #(.NPIN(NPIN)) u_rmux (
    .rd_en    (acc_op == ACC_READ),
    .dir_q    (dir_q),
    .drv_q    (drv_q),
    .sample_q (sample_q),
    .rdata    (acc_rdata)
  );

  assign pin_oe  = dir_q;
  assign pin_out = drv_q;

  logic [DATA_W-1:STEER_B+1] unused_wdata_hi;
  assign unused_wdata_hi = acc_wdata[DATA_W-1:STEER_B+1];
endmodule

// File: rtl/sfp_port_chk.sv
module sfp_port_chk #(
  parameter int NPIN   = 8,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_en_n,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              acc_write,
  input logic [2*NPIN-1:0] acc_wdata,
  input logic [2*NPIN-1:0] acc_rdata,
  input logic [NPIN-1:0]   pin_in,
  input logic [NPIN-1:0]   pin_oe,
  input logic [NPIN-1:0]   pin_out
);
  logic sel;
  logic rd;
  logic wr;
  logic [1:0] age_q;

  assign sel = !acc_en_n && (acc_addr == '0);
  assign rd  = sel && !acc_write;
  assign wr  = sel && acc_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  // R2
  a_r2_dir_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && acc_wdata[NPIN]) |=> (pin_oe == $past(acc_wdata[NPIN-1:0])));

  // R3
  a_r3_drive_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !acc_wdata[NPIN]) |=>
      (pin_out == (($past(pin_out) & ~$past(pin_oe)) |
                   ($past(acc_wdata[NPIN-1:0]) & $past(pin_oe)))));

  // R9
  a_r9_dir_keeps_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && acc_wdata[NPIN]) |=> $stable(pin_out));

  // R8
  a_r8_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> ($stable(pin_oe) && $stable(pin_out)));

  // R8
  a_r8_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |-> (acc_rdata == '0));

  // R6
  a_r6_dir_byte: assert property (@(posedge clk) disable iff (!rst_n)
    rd |-> (acc_rdata[2*NPIN-1:NPIN] == pin_oe));

  // R5
  a_r5_output_bits: assert property (@(posedge clk) disable iff (!rst_n)
    rd |-> ((acc_rdata[NPIN-1:0] & pin_oe) == (pin_out & pin_oe)));

  // R7
  a_r7_two_edge_sample: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && age_q >= 2'd2) |->
      ((acc_rdata[NPIN-1:0] & ~pin_oe) == ($past(pin_in, 2) & ~pin_oe)));
endmodule

bind sfp_port sfp_port_chk #(.NPIN(NPIN), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .acc_en_n  (acc_en_n),
  .acc_addr  (acc_addr),
  .acc_write (acc_write),
  .acc_wdata (acc_wdata),
  .acc_rdata (acc_rdata),
  .pin_in    (pin_in),
  .pin_oe    (pin_oe),
  .pin_out   (pin_out)
);

// File: tb/sfp_port_bench.sv
`timescale 1ns/1ps
module sfp_port_bench;
  localparam int NPIN = 8;
  localparam int AW   = 2;

  logic        clk;
  logic        rst_n;
  logic        acc_en_n;
  logic [AW-1:0] acc_addr;
  logic        acc_write;
  logic [15:0] acc_wdata;
  logic [15:0] acc_rdata;
  logic [7:0]  pin_in;
  logic [7:0]  pin_oe;
  logic [7:0]  pin_out;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  sfp_port u_sfp_port (
    .clk(clk), .rst_n(rst_n), .acc_en_n(acc_en_n), .acc_addr(acc_addr),
    .acc_write(acc_write), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic        en_n;
    logic [1:0]  addr;
    logic        wr;
    logic [15:0] wdata;
    logic [7:0]  pins;
    logic        chk_rd;
    logic [15:0] exp_rd;
    logic [7:0]  exp_oe;
    logic [7:0]  exp_out;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 2'd0, 1'b1, 16'h01F0, 8'h5A, 1'b0, 16'h0000, 8'hF0, 8'h00},
    '{1'b0, 2'd0, 1'b1, 16'h00AA, 8'h5A, 1'b0, 16'h0000, 8'hF0, 8'hA0},
    '{1'b1, 2'd0, 1'b0, 16'h0000, 8'h5A, 1'b0, 16'h0000, 8'hF0, 8'hA0},
    '{1'b0, 2'd0, 1'b0, 16'h0000, 8'h5A, 1'b1, 16'hF0AA, 8'hF0, 8'hA0},
    '{1'b0, 2'd0, 1'b1, 16'h010F, 8'h5A, 1'b0, 16'h0000, 8'h0F, 8'hA0},
    '{1'b0, 2'd0, 1'b0, 16'h0000, 8'hC3, 1'b1, 16'h0F50, 8'h0F, 8'hA0},
    '{1'b0, 2'd0, 1'b1, 16'h00FF, 8'hC3, 1'b0, 16'h0000, 8'h0F, 8'hAF},
    '{1'b0, 2'd0, 1'b0, 16'h0000, 8'hC3, 1'b1, 16'h0FCF, 8'h0F, 8'hAF},
    '{1'b0, 2'd1, 1'b1, 16'h0100, 8'hC3, 1'b0, 16'h0000, 8'h0F, 8'hAF},
    '{1'b0, 2'd1, 1'b0, 16'h0000, 8'hC3, 1'b1, 16'h0000, 8'h0F, 8'hAF},
    '{1'b1, 2'd0, 1'b1, 16'h0000, 8'hC3, 1'b0, 16'h0000, 8'h0F, 8'hAF},
    '{1'b1, 2'd0, 1'b0, 16'h0000, 8'hC3, 1'b1, 16'h0000, 8'h0F, 8'hAF},
    '{1'b0, 2'd0, 1'b1, 16'h01FF, 8'hC3, 1'b0, 16'h0000, 8'hFF, 8'hAF},
    '{1'b0, 2'd0, 1'b0, 16'h0000, 8'h00, 1'b1, 16'hFFAF, 8'hFF, 8'hAF},
    '{1'b0, 2'd0, 1'b1, 16'h0012, 8'h00, 1'b0, 16'h0000, 8'hFF, 8'h12},
    '{1'b0, 2'd0, 1'b1, 16'h0100, 8'h00, 1'b0, 16'h0000, 8'h00, 8'h12},
    '{1'b0, 2'd0, 1'b0, 16'h0000, 8'h00, 1'b1, 16'h0000, 8'h00, 8'h12},
    '{1'b0, 2'd0, 1'b1, 16'h00FF, 8'h00, 1'b0, 16'h0000, 8'h00, 8'h12},
    '{1'b0, 2'd0, 1'b1, 16'h01FF, 8'h00, 1'b0, 16'h0000, 8'hFF, 8'h12},
    '{1'b0, 2'd0, 1'b0, 16'h0000, 8'h00, 1'b1, 16'hFF12, 8'hFF, 8'h12}
  };

  task automatic check(input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic bus_idle();
    acc_en_n  = 1'b1;
    acc_addr  = '0;
    acc_write = 1'b0;
    acc_wdata = '0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    rst_n  = 1'b0;
    pin_in = 8'h00;
    bus_idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: state held at zero during reset
    check("R1 oe in reset",  {8'h0, pin_oe},  16'h0000);
    check("R1 out in reset", {8'h0, pin_out}, 16'h0000);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    acc_en_n = 1'b0;
    #1;
    check("R1 read after reset", acc_rdata, 16'h0000);
    check("R1 oe after reset", {8'h0, pin_oe}, 16'h0000);
    bus_idle();

    // Table walk
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      acc_en_n  = TBL[k].en_n;
      acc_addr  = TBL[k].addr;
      acc_write = TBL[k].wr;
      acc_wdata = TBL[k].wdata;
      pin_in    = TBL[k].pins;
      #1;
      if (TBL[k].chk_rd) begin
        if (TBL[k].en_n || TBL[k].addr != 0)
          check($sformatf("R8 unselected read v%0d", k), acc_rdata, TBL[k].exp_rd);
        else
          check($sformatf("R5 R6 read v%0d", k), acc_rdata, TBL[k].exp_rd);
      end
      @(posedge clk);
      @(negedge clk);
      check($sformatf("R2 R4 oe v%0d", k), {8'h0, pin_oe}, {8'h0, TBL[k].exp_oe});
      check($sformatf("R3 R9 R4 out v%0d", k), {8'h0, pin_out}, {8'h0, TBL[k].exp_out});
    end
    bus_idle();

    // R7: input sample latency, all pins as inputs
    @(negedge clk);
    acc_en_n = 1'b0; acc_write = 1'b1; acc_wdata = 16'h0100;
    @(negedge clk);
    acc_write = 1'b0; acc_wdata = 16'h0000;
    pin_in = 8'h3C;
    #1;
    check("R7 zero edges", acc_rdata, 16'h0000);
    @(negedge clk);
    check("R7 one edge", acc_rdata, 16'h0000);
    @(negedge clk);
    check("R7 two edges", acc_rdata, 16'h003C);
    check("R8 read keeps drive", {8'h0, pin_out}, 16'h0012);
    bus_idle();

    // R1: asynchronous reset in mid-run clears state at once
    @(negedge clk);
    acc_en_n = 1'b0; acc_write = 1'b1; acc_wdata = 16'h01FF;
    @(negedge clk);
    bus_idle();
    #1;
    rst_n = 1'b0;
    #1;
    check("R1 async oe", {8'h0, pin_oe}, 16'h0000);
    check("R1 async out", {8'h0, pin_out}, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule